// File: doc/BRIEF.md
# Binary-Weight Parallel Accumulator Array

This block carries out the multiply-free inner step of a convolution layer whose weights are reduced to single sign bits. Each accepted beat delivers one signed fixed-point operand together with a vector of sign bits, one bit for each output channel. Every channel owns an accumulator. A channel adds the operand when its sign bit is set and subtracts it when the bit is clear. No multiplier is involved.

A flag sent with the first beat of a sequence makes every channel start from the new term instead of its old total. Once the sequence is complete, a start pulse moves the block into an output phase. In that phase the channel totals leave one per cycle, in channel order, through a write port. Each total is clamped to the operand width on the way out. The write addresses count upward from a base address captured with the start pulse. A one-cycle completion pulse follows the last write, and the block then takes input again.

The block is meant to sit between an operand buffer and a result buffer. Because it never stalls inside a sequence, the upstream reader only has to watch the ready output.

Top module: `bwacc_array`

## Requirements
- R1: After reset, in_ready is 1, wr_en is 0, done is 0, and every accumulator holds zero, so a drain issued straight after reset writes zero for every channel.
- R2: For an accepted beat, channel p (bit p of in_wbits, bit 0 = channel 0) adds the signed operand when its bit is 1 and subtracts it when its bit is 0.
- R3: An accepted beat with in_first = 1 makes each channel hold only that beat's signed term, whatever it held before.
- R4: The accumulators are DATA_W + clog2(MAX_VECS) + 1 bits wide, so a sequence of up to MAX_VECS beats, including operands of -2^(DATA_W-1), never wraps.
- R5: When drain_start is 1 while in_ready is 1, the next cycle begins exactly LANES consecutive cycles with wr_en = 1, which carry channels 0, 1, ..., LANES-1 in that order.
- R6: The first write goes to the wr_base value captured with drain_start, and each later write goes to the previous address plus one, modulo 2^ADDR_W.
- R7: wr_data is the channel total clamped to the signed DATA_W range: totals above 2^(DATA_W-1)-1 give that maximum, totals below -2^(DATA_W-1) give that minimum, and other totals pass through unchanged.
- R8: done is 1 for exactly one cycle, namely the cycle right after the last write. In that same cycle in_ready is 1 again and wr_en is 0.
- R9: While writes are in progress, in_ready is 0, and in_valid, in_first and drain_start have no effect. The output phase itself leaves the accumulators unchanged, so a second drain writes the same values again.
- R10: A beat presented in the same cycle as an accepted drain_start is accumulated, and it is included in the values that drain writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Beat present on in_data / in_wbits |
| in_first | input | 1 | Beat opens a new sequence |
| in_data | input | DATA_W | Signed fixed-point operand |
| in_wbits | input | LANES | Sign bit per channel, 1 = add |
| drain_start | input | 1 | Begin writing out the channel totals |
| wr_base | input | ADDR_W | Base address, captured with drain_start |
| in_ready | output | 1 | Block accepts beats and drain_start |
| wr_en | output | 1 | Write strobe toward the result buffer |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Clamped channel total |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
The bench builds the block with four channels, 8-bit operands, a sequence limit of 16 beats and 6-bit addresses. These values keep every saturation edge within reach. A run of sixteen beats of -128 reaches a magnitude of 2048, which wraps an accumulator that lacks the extra guard bit. Eight beats of 100 overflow the 8-bit output range in both directions. A base of 62 forces the write address to roll over inside a single drain. With four channels, the channel order and the mapping of sign bits to channels are visible in every drain, and the lanes are few enough that each one can be checked after each sequence.

// File: rtl/bwacc_pkg.sv
package bwacc_pkg;

    typedef enum logic {
        PH_GATHER = 1'b0,
        PH_DRAIN  = 1'b1
    } phase_e;

    // Guard bits so that MAX_VECS terms of full-scale magnitude never wrap.
    function automatic int acc_width(input int data_w, input int max_vecs);
        return data_w + $clog2(max_vecs) + 1;
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bwacc_lane.sv
module bwacc_lane #(
    parameter int DATA_W = 8,
    parameter int ACC_W  = 13
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     first,
    input  logic                     add_n_sub,
    input  logic signed [DATA_W-1:0] x,
    output logic signed [ACC_W-1:0]  acc
);

    localparam int EXT_W = ACC_W - DATA_W;

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] term;
    logic signed [ACC_W-1:0] origin;

    assign x_ext  = {{EXT_W{x[DATA_W-1]}}, x};
    assign term   = add_n_sub ? x_ext : -x_ext;
    assign origin = first ? '0 : acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (en) begin
            acc <= origin + term;
        end
    end

    // R9: a channel only moves on an accepted beat
    a_r9_lane_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc));

endmodule

// File: rtl/bwacc_sat.sv
module bwacc_sat #(
    parameter int IN_W  = 13,
    parameter int OUT_W = 8
) (
    input  logic signed [IN_W-1:0]  in_v,
    output logic signed [OUT_W-1:0] out_v
);

    localparam logic signed [IN_W-1:0] HI =
        {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W-1:0] LO =
        {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    always_comb begin
        if (in_v > HI) begin
            out_v = HI[OUT_W-1:0];
        end else if (in_v < LO) begin
            out_v = LO[OUT_W-1:0];
        end else begin
            out_v = in_v[OUT_W-1:0];
        end
    end

    // R7: clamping never flips the sign of a total
    always_comb begin
        a_r7_sign_kept: assert (in_v[IN_W-1] == out_v[OUT_W-1]);
    end

endmodule

// File: rtl/bwacc_drain_ctrl.sv
module bwacc_drain_ctrl
    import bwacc_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int ADDR_W = 6,
    localparam int IDX_W = idx_width(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    output logic              busy,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_GATHER;
            idx   <= '0;
            addr  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_GATHER: begin
                    if (start) begin
                        phase <= PH_DRAIN;
                        idx   <= '0;
                        addr  <= base;
                    end
                end
                PH_DRAIN: begin
                    addr <= addr + ADDR_W'(1);
                    if (idx == LAST) begin
                        phase <= PH_GATHER;
                        idx   <= '0;
                        done  <= 1'b1;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                default: phase <= PH_GATHER;
            endcase
        end
    end

    assign busy = (phase == PH_DRAIN);

    // R5: an accepted start opens the output phase on the next cycle
    a_r5_start_enters: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

    // R6: consecutive writes step the address by one
    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (addr == ADDR_W'($past(addr) + ADDR_W'(1))));

    // R8: completion pulse is one cycle wide
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: completion follows the last write and the phase has ended
    a_r8_done_after_write: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy) && ($past(idx) == LAST)));

endmodule

// File: rtl/bwacc_array.sv
module bwacc_array
    import bwacc_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int DATA_W   = 8,
    parameter int MAX_VECS = 16,
    parameter int ADDR_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [DATA_W-1:0] in_data,
    input  logic [LANES-1:0]  in_wbits,
    input  logic              drain_start,
    input  logic [ADDR_W-1:0] wr_base,
    output logic              in_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              done
);

    localparam int ACC_W = acc_width(DATA_W, MAX_VECS);
    localparam int IDX_W = idx_width(LANES);

    logic                    busy;
    logic                    accept;
    logic [IDX_W-1:0]        sel_idx;
    logic signed [ACC_W-1:0] lane_acc [LANES];
    logic signed [ACC_W-1:0] sel_acc;
    logic signed [DATA_W-1:0] clamped;

    assign accept = in_valid && !busy;

    for (genvar p = 0; p < LANES; p++) begin : g_lane
        bwacc_lane #(
            .DATA_W (DATA_W),
            .ACC_W  (ACC_W)
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .en        (accept),
            .first     (in_first),
            .add_n_sub (in_wbits[p]),
            .x         (in_data),
            .acc       (lane_acc[p])
        );
    end

    bwacc_drain_ctrl #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (drain_start),
        .base  (wr_base),
        .busy  (busy),
        .idx   (sel_idx),
        .addr  (wr_addr),
        .done  (done)
    );

    always_comb begin
        sel_acc = lane_acc[0];
        for (int p = 0; p < LANES; p++) begin
            if (sel_idx == IDX_W'(p)) begin
                sel_acc = lane_acc[p];
            end
        end
    end

    bwacc_sat #(
        .IN_W  (ACC_W),
        .OUT_W (DATA_W)
    ) u_sat (
        .in_v  (sel_acc),
        .out_v (clamped)
    );

    assign wr_data  = clamped;
    assign wr_en    = busy;
    assign in_ready = !busy;

    // R9: no beat slips in while the totals are leaving
    a_r9_no_accept_in_drain: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !accept);

    // R5: writes form one unbroken run that ends with the completion pulse
    a_r5_run_ends_in_done: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_en) |-> done);

endmodule

// File: tb/sim_bwacc_array.sv
module sim_bwacc_array;

    localparam int P = 4;
    localparam int N = 8;
    localparam int AW = 6;
    localparam int NSTIM = 11;

    // {drain_after, first, repeat[4:0], data[7:0], wbits[3:0]}
    localparam logic [18:0] STIM [NSTIM] = '{
        {1'b0, 1'b1, 5'd1,  8'd10,  4'b1111},
        {1'b0, 1'b0, 5'd1,  8'd5,   4'b0101},
        {1'b1, 1'b0, 5'd1,  8'hFD,  4'b1000},
        {1'b0, 1'b1, 5'd1,  8'd100, 4'b0011},
        {1'b1, 1'b0, 5'd7,  8'd100, 4'b0011},
        {1'b1, 1'b1, 5'd1,  8'd7,   4'b1010},
        {1'b0, 1'b1, 5'd1,  8'h80,  4'b0001},
        {1'b1, 1'b0, 5'd15, 8'h80,  4'b0001},
        {1'b0, 1'b1, 5'd1,  8'h7F,  4'b1100},
        {1'b0, 1'b0, 5'd1,  8'h81,  4'b0110},
        {1'b1, 1'b0, 5'd1,  8'd0,   4'b1111}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_first = 1'b0;
    logic [N-1:0]  in_data = '0;
    logic [P-1:0]  in_wbits = '0;
    logic          drain_start = 1'b0;
    logic [AW-1:0] wr_base = '0;
    logic          in_ready;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [N-1:0]  wr_data;
    logic          done;

    int checks = 0;
    int fails  = 0;
    int mdl [P];

    always #2.5 clk = ~clk;

    bwacc_array #(
        .LANES    (P),
        .DATA_W   (N),
        .MAX_VECS (16),
        .ADDR_W   (AW)
    ) u0 (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_first    (in_first),
        .in_data     (in_data),
        .in_wbits    (in_wbits),
        .drain_start (drain_start),
        .wr_base     (wr_base),
        .in_ready    (in_ready),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .done        (done)
    );

    function automatic int clamp(input int v);
        if (v > 127) return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_beat(input bit first, input logic [N-1:0] x, input logic [P-1:0] w);
        for (int p = 0; p < P; p++) begin
            if (first) mdl[p] = 0;
            mdl[p] += w[p] ? int'($signed(x)) : -int'($signed(x));
        end
    endtask

    // called at a negative edge with the inputs idle
    task automatic run_beats(input bit first, input int rep, input logic [N-1:0] x,
                             input logic [P-1:0] w);
        for (int r = 0; r < rep; r++) begin
            in_valid = 1'b1;
            in_first = first && (r == 0);
            in_data  = x;
            in_wbits = w;
            model_beat(first && (r == 0), x, w);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_first = 1'b0;
    endtask

    // drain; poke drives input and a second start during the writes;
    // with_beat presents a beat in the same cycle as the start
    task automatic do_drain(input string req, input logic [AW-1:0] b, input bit poke,
                            input bit with_beat, input logic [N-1:0] bx,
                            input logic [P-1:0] bw);
        drain_start = 1'b1;
        wr_base     = b;
        if (with_beat) begin
            in_valid = 1'b1;
            in_first = 1'b0;
            in_data  = bx;
            in_wbits = bw;
            model_beat(1'b0, bx, bw);
        end
        @(negedge clk);
        drain_start = 1'b0;
        in_valid    = 1'b0;
        wr_base     = 6'h15;
        if (poke) begin
            in_valid    = 1'b1;
            in_first    = 1'b1;
            in_data     = 8'd50;
            in_wbits    = 4'b1111;
            drain_start = 1'b1;
        end
        for (int k = 0; k < P; k++) begin
            chk("R5", "wr_en during drain", int'(wr_en), 1);
            chk("R9", "in_ready during drain", int'(in_ready), 0);
            chk("R6", "wr_addr", int'(wr_addr), int'(AW'(b + AW'(k))));
            chk(req, $sformatf("wr_data lane %0d", k), int'($signed(wr_data)), clamp(mdl[k]));
            @(negedge clk);
        end
        in_valid    = 1'b0;
        in_first    = 1'b0;
        drain_start = 1'b0;
        chk("R8", "done after last write", int'(done), 1);
        chk("R8", "in_ready with done", int'(in_ready), 1);
        chk("R8", "wr_en with done", int'(wr_en), 0);
        @(negedge clk);
        chk("R8", "done width", int'(done), 0);
        chk("R9", "no restart from start during drain", int'(wr_en), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < P; p++) mdl[p] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: idle state after reset
        chk("R1", "in_ready", int'(in_ready), 1);
        chk("R1", "wr_en", int'(wr_en), 0);
        chk("R1", "done", int'(done), 0);
        do_drain("R1", 6'd0, 1'b0, 1'b0, '0, '0);

        // table walk: R2 sign per lane, R3 first, R4 long runs, R7 clamp
        for (int i = 0; i < NSTIM; i++) begin
            run_beats(STIM[i][17], int'(STIM[i][16:12]), STIM[i][11:4], STIM[i][3:0]);
            if (STIM[i][18]) begin
                do_drain((i == 7) ? "R4" : (i == 4) ? "R7" : (i == 5) ? "R3" : "R2",
                         AW'(i * 7 + 3), 1'b0, 1'b0, '0, '0);
            end
        end

        // R9: input and a second start during the drain are ignored
        run_beats(1'b1, 1, 8'd20, 4'b0110);
        run_beats(1'b0, 1, 8'd9, 4'b1100);
        do_drain("R9", 6'd8, 1'b1, 1'b0, '0, '0);
        do_drain("R9", 6'd8, 1'b0, 1'b0, '0, '0);

        // R10: beat in the same cycle as the start is included
        run_beats(1'b1, 1, 8'd11, 4'b1111);
        do_drain("R10", 6'd30, 1'b0, 1'b1, 8'd4, 4'b0011);

        // R6: address rolls over inside a drain
        do_drain("R6", 6'd62, 1'b0, 1'b0, '0, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule